// File: doc/BRIEF.md
# SPI Slave Message Framer

This block sits on the peripheral side of a 16-bit-word SPI link. It breaks each message from the host into four fixed transactions. First the host sends a three-word header. Next the host sends its data. The block then answers with a two-word length reply and finally with its own reply data. The command and every received word go to local logic on single-cycle strobes. Local logic supplies the reply length and pays out the reply words one at a time as the host clocks them.

A single acknowledge output tells the host when the block is ready to move on. After each completed transaction it gives a short pulse. When local serial-port data is waiting and no message is under way, it holds the line high instead. While that level is held, the host clocks the waiting words out directly, outside the message format. A separate start input throws away any partial message and returns the block to waiting for a header. Start is refused while the serial level is held.

SPI is sampled in mode 0 on the system clock. SCLK, chip select, MOSI and start each pass through a two-flop synchroniser. All framing counts are clamped, so a corrupted count cannot push the block past its configured buffer depth.

Top module: `spi_msg_framer`

## Requirements
- R1: After reset, `ack_o`, `spi_miso`, `cmd_valid_o`, `rx_valid_o`, `rep_pop_o` and `uart_pop_o` are all low.
- R2: The header transaction is three words: the sync value SYNC_WORD (default 0xCB07), a command word, and a host word count. When the third word completes, `cmd_valid_o` strobes for one cycle with the command on `cmd_o` and the clamped count on `count_o`, and one acknowledge pulse follows.
- R3: If the first header word differs from SYNC_WORD, that word is discarded, the block keeps waiting for a sync word, and no acknowledge pulse is issued.
- R4: The host data transaction carries a count clamped to the range 1..MAX_WORDS, where a raw 0 becomes 1. Each word is presented on `rx_word_o` with a one-cycle `rx_valid_o`, and an acknowledge pulse follows the last word.
- R5: The length transaction shifts out two words on `spi_miso`. The first is `rep_len_i` clamped to 1..MAX_WORDS, sampled as the last host data word completes. The second is 0x0000. An acknowledge pulse follows.
- R6: The reply transaction shifts out the clamped reply length of words taken from `rep_word_i`. `rep_pop_o` strobes once after each word, an acknowledge pulse follows the last word, and the block then waits for a new header.
- R7: A rising edge on `start_i`, outside the held serial state, abandons any partial message, returns the block to waiting for a sync word, and emits one acknowledge pulse.
- R8: Every acknowledge pulse is high for exactly ACK_CYCLES system clocks (default 4).
- R9: While `uart_pend_i` is high and the block is waiting for a sync word with no pulse in flight, `ack_o` is held high. Each 16-bit word clocked during this time shifts out `uart_word_i` and strobes `uart_pop_o`. `ack_o` falls once `uart_pend_i` goes low.
- R10: A rising edge on `start_i` while `ack_o` is held for serial data has no effect: the level stays high, no extra pulse starts, and the next word still shifts out `uart_word_i`.
- R11: SPI is mode 0 and MSB first. MOSI is captured on rising SCLK. Deasserting `spi_cs_n` discards a partially received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| start_i | input | 1 | Framing restart request from host |
| ack_o | output | 1 | Acknowledge pulse / held serial-pending level |
| cmd_o | output | 16 | Command word of the current message |
| count_o | output | 16 | Clamped host data count, valid with cmd_valid_o |
| cmd_valid_o | output | 1 | Header complete strobe |
| rx_word_o | output | 16 | Received host data word |
| rx_valid_o | output | 1 | Host data word strobe |
| rep_len_i | input | 16 | Requested reply length from local logic |
| rep_word_i | input | 16 | Current reply word from local logic |
| rep_pop_o | output | 1 | Reply word consumed strobe |
| uart_pend_i | input | 1 | Local serial data waiting |
| uart_word_i | input | 16 | Current serial word to send |
| uart_pop_o | output | 1 | Serial word consumed strobe |

## Verification
A wrong framing state shows at the ports within one acknowledge interval. Either a pulse is missing or extra after a transaction, or `spi_miso` carries the wrong word in the very next length or reply transaction. A miscounted host data transaction moves the length word off by whole words, so the bench catches it on the first bit of the following transaction. A broken held-level path shows as `ack_o` falling during a pending serial burst, or as the framed reply words appearing in place of the serial word.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  localparam int WORD_W = 16;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_DATA,
    ST_LEN,
    ST_REPLY,
    ST_HOLD
  } frm_state_t;

  // Raw count forced into 1..maxw
  function automatic word_t clamp_words(input word_t raw, input word_t maxw);
    if (raw == '0)  return word_t'(1);
    if (raw > maxw) return maxw;
    return raw;
  endfunction
endpackage

// File: rtl/spi_word_rx.sv
module spi_word_rx
  import spi_frm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  sclk_i,
  input  logic  cs_n_i,
  input  logic  mosi_i,
  input  word_t tx_word_i,
  output logic  miso_o,
  output word_t word_o,
  output logic  word_done_o
);
  localparam logic [BIT_W-1:0] TOP = BIT_W'(WORD_W - 1);

  logic [2:0]       sclk_sy;
  logic [1:0]       cs_sy;
  logic [1:0]       mosi_sy;
  logic [BIT_W-1:0] bitcnt;
  word_t            sh;

  wire sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  wire cs_active = ~cs_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy     <= '0;
      cs_sy       <= '1;
      mosi_sy     <= '0;
      bitcnt      <= '0;
      sh          <= '0;
      word_o      <= '0;
      word_done_o <= 1'b0;
    end else begin
      sclk_sy     <= {sclk_sy[1:0], sclk_i};
      cs_sy       <= {cs_sy[0], cs_n_i};
      mosi_sy     <= {mosi_sy[0], mosi_i};
      word_done_o <= 1'b0;
      if (clr_i || !cs_active) begin
        bitcnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[WORD_W-2:0], mosi_sy[1]};
        if (bitcnt == TOP) begin
          bitcnt      <= '0;
          word_o      <= {sh[WORD_W-2:0], mosi_sy[1]};
          word_done_o <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // MSB first: bit position counts down from the top
  assign miso_o = cs_active ? tx_word_i[TOP - bitcnt] : 1'b0;

  // R11
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (bitcnt == '0));
endmodule

// File: rtl/ack_pulse_gen.sv
module ack_pulse_gen #(
  parameter int ACK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(ACK_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (trig_i)         cnt <= CW'(ACK_CYCLES);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign pulse_o = (cnt != '0);

  generate
    if (ACK_CYCLES > 1) begin : g_width_chk
      // R8
      ack_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import spi_frm_pkg::*;
#(
  parameter word_t SYNC_WORD = 16'hCB07,
  parameter int    MAX_WORDS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  word_t word_i,
  input  logic  word_done_i,
  input  word_t rep_len_i,
  input  word_t rep_word_i,
  input  logic  uart_pend_i,
  input  word_t uart_word_i,
  input  logic  ack_busy_i,
  output word_t tx_word_o,
  output logic  start_evt_o,
  output logic  ack_trig_o,
  output logic  hold_o,
  output word_t cmd_o,
  output word_t count_o,
  output logic  cmd_valid_o,
  output word_t rx_word_o,
  output logic  rx_valid_o,
  output logic  rep_pop_o,
  output logic  uart_pop_o
);
  localparam word_t MAXW = word_t'(MAX_WORDS);

  frm_state_t state;
  word_t      wcnt, hcnt, rlen, cmd_q;
  logic [2:0] st_sy;

  wire start_rise = st_sy[1] & ~st_sy[2];
  wire start_evt  = start_rise && (state != ST_HOLD);
  wire hdr_last   = (state == ST_HDR)   && (wcnt == word_t'(2));
  wire data_last  = (state == ST_DATA)  && (wcnt == hcnt - 1'b1);
  wire len_last   = (state == ST_LEN)   && (wcnt == word_t'(1));
  wire rep_last   = (state == ST_REPLY) && (wcnt == rlen - 1'b1);
  wire txn_done   = word_done_i && (hdr_last || data_last || len_last || rep_last);
  wire bad_sync   = word_done_i && (state == ST_HDR) && (wcnt == '0) && (word_i != SYNC_WORD);
  wire hold_enter = (state == ST_HDR) && (wcnt == '0) && uart_pend_i && !ack_busy_i && !start_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sy <= '0;
      state <= ST_HDR;
      wcnt  <= '0;
      hcnt  <= word_t'(1);
      rlen  <= word_t'(1);
      cmd_q <= '0;
    end else begin
      st_sy <= {st_sy[1:0], start_i};
      if (start_evt) begin
        state <= ST_HDR;
        wcnt  <= '0;
      end else if (state == ST_HOLD) begin
        if (!uart_pend_i) state <= ST_HDR;
      end else if (hold_enter && !word_done_i) begin
        state <= ST_HOLD;
      end else if (word_done_i) begin
        unique case (state)
          ST_HDR: begin
            if (wcnt == '0) begin
              if (!bad_sync) wcnt <= word_t'(1);
            end else if (wcnt == word_t'(1)) begin
              cmd_q <= word_i;
              wcnt  <= word_t'(2);
            end else begin
              hcnt  <= clamp_words(word_i, MAXW);
              state <= ST_DATA;
              wcnt  <= '0;
            end
          end
          ST_DATA: begin
            if (data_last) begin
              rlen  <= clamp_words(rep_len_i, MAXW);
              state <= ST_LEN;
              wcnt  <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
          ST_LEN: begin
            if (len_last) begin
              state <= ST_REPLY;
              wcnt  <= '0;
            end else wcnt <= word_t'(1);
          end
          ST_REPLY: begin
            if (rep_last) begin
              state <= ST_HDR;
              wcnt  <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_LEN:   tx_word_o = (wcnt == '0) ? rlen : '0;
      ST_REPLY: tx_word_o = rep_word_i;
      ST_HOLD:  tx_word_o = uart_word_i;
      default:  tx_word_o = '0;
    endcase
  end

  assign start_evt_o = start_evt;
  assign ack_trig_o  = start_evt || txn_done;
  assign hold_o      = (state == ST_HOLD);
  assign cmd_o       = cmd_q;
  assign count_o     = clamp_words(word_i, MAXW);
  assign cmd_valid_o = word_done_i && hdr_last && !start_evt;
  assign rx_word_o   = word_i;
  assign rx_valid_o  = word_done_i && (state == ST_DATA) && !start_evt;
  assign rep_pop_o   = word_done_i && (state == ST_REPLY) && !start_evt;
  assign uart_pop_o  = word_done_i && (state == ST_HOLD);

  // R3
  bad_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sync && !start_evt |=> (state == ST_HDR) && (wcnt == '0));
  // R10
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) && start_rise && uart_pend_i |=> (state == ST_HOLD));
  // R4
  data_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (wcnt < hcnt) && (hcnt <= MAXW));
  // R6
  reply_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REPLY) |-> (wcnt < rlen) && (rlen != '0));
endmodule

// File: rtl/spi_msg_framer.sv
module spi_msg_framer
  import spi_frm_pkg::*;
#(
  parameter logic [15:0] SYNC_WORD  = 16'hCB07,
  parameter int          MAX_WORDS  = 8,
  parameter int          ACK_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic        start_i,
  output logic        ack_o,
  output logic [15:0] cmd_o,
  output logic [15:0] count_o,
  output logic        cmd_valid_o,
  output logic [15:0] rx_word_o,
  output logic        rx_valid_o,
  input  logic [15:0] rep_len_i,
  input  logic [15:0] rep_word_i,
  output logic        rep_pop_o,
  input  logic        uart_pend_i,
  input  logic [15:0] uart_word_i,
  output logic        uart_pop_o
);
  word_t word_w, tx_word_w;
  logic  word_done_w, start_evt_w, ack_trig_w, hold_w, pulse_w;

  spi_word_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_evt_w),
    .sclk_i     (spi_sclk),
    .cs_n_i     (spi_cs_n),
    .mosi_i     (spi_mosi),
    .tx_word_i  (tx_word_w),
    .miso_o     (spi_miso),
    .word_o     (word_w),
    .word_done_o(word_done_w)
  );

  frame_ctrl #(.SYNC_WORD(SYNC_WORD), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .word_i     (word_w),
    .word_done_i(word_done_w),
    .rep_len_i  (rep_len_i),
    .rep_word_i (rep_word_i),
    .uart_pend_i(uart_pend_i),
    .uart_word_i(uart_word_i),
    .ack_busy_i (pulse_w),
    .tx_word_o  (tx_word_w),
    .start_evt_o(start_evt_w),
    .ack_trig_o (ack_trig_w),
    .hold_o     (hold_w),
    .cmd_o      (cmd_o),
    .count_o    (count_o),
    .cmd_valid_o(cmd_valid_o),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o),
    .rep_pop_o  (rep_pop_o),
    .uart_pop_o (uart_pop_o)
  );

  ack_pulse_gen #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (ack_trig_w),
    .pulse_o(pulse_w)
  );

  assign ack_o = pulse_w | hold_w;

  // R7
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt_w |=> ack_o);
endmodule

// File: tb/spi_msg_framer_tb.sv
module spi_msg_framer_tb;
  localparam int MAXW = 8;
  localparam int ACKW = 4;

  logic        clk = 0, rst_n = 0;
  logic        sclk = 0, cs_n = 1, mosi = 0, start = 0, pend = 0;
  logic [15:0] rep_len = 16'd1, uart_word = 16'h0;
  logic [15:0] rep_word;
  wire         miso, ack, cmd_valid, rx_valid, rep_pop, uart_pop;
  wire  [15:0] cmd, count, rx_word;

  spi_msg_framer #(.MAX_WORDS(MAXW), .ACK_CYCLES(ACKW)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .start_i(start), .ack_o(ack), .cmd_o(cmd), .count_o(count),
    .cmd_valid_o(cmd_valid), .rx_word_o(rx_word), .rx_valid_o(rx_valid),
    .rep_len_i(rep_len), .rep_word_i(rep_word), .rep_pop_o(rep_pop),
    .uart_pend_i(pend), .uart_word_i(uart_word), .uart_pop_o(uart_pop)
  );

  always #10 clk = ~clk;

  typedef struct { int kind; logic [15:0] a; logic [15:0] b; } item_t;
  item_t sb_q[$];

  int total = 0, bad = 0, rises = 0, exp_rises = 0, width = 0;
  int pop_total = 0, rep_base = 0;
  bit ack_prev = 0, hold_flag = 0, done = 0;
  logic [15:0] rep_mem [16];

  assign rep_word = rep_mem[(pop_total - rep_base) & 15];

  function automatic logic [15:0] tb_clamp(input logic [15:0] raw);
    return (raw == 0) ? 16'd1 : ((raw > MAXW) ? 16'(MAXW) : raw);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops, ack edges and widths
  always @(negedge clk) begin
    if (rep_pop) pop_total <= pop_total + 1;
    if (cmd_valid || rx_valid || uart_pop) begin
      item_t it;
      int kind;
      kind = cmd_valid ? 0 : (rx_valid ? 1 : 2);
      if (sb_q.size() == 0) chk(0, "R2/R4/R9 unexpected strobe", kind, -1);
      else begin
        it = sb_q.pop_front();
        if (kind == 0) begin
          chk(it.kind == 0 && cmd == it.a, "R2 cmd", cmd, it.a);
          chk(count == it.b, "R2 count", count, it.b);
        end else if (kind == 1) chk(it.kind == 1 && rx_word == it.a, "R4 rx word", rx_word, it.a);
        else chk(it.kind == 2, "R9 uart pop", kind, it.kind);
      end
    end
    if (ack && !ack_prev) rises++;
    if (ack) width++;
    if (!ack && ack_prev) begin
      if (!hold_flag) chk(width == ACKW, "R8 pulse width", width, ACKW);
      width = 0;
    end
    ack_prev = ack;
  end

  task automatic spi_bits(input logic [15:0] tx, input int n, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i > 15 - n; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_lo(); @(negedge clk) cs_n = 0; repeat (4) @(negedge clk); endtask
  task automatic cs_hi(); repeat (2) @(negedge clk); cs_n = 1; repeat (10) @(negedge clk); endtask

  task automatic ack_chk(input string req);
    repeat (4) @(negedge clk);
    chk(rises == exp_rises, req, rises, exp_rises);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1; repeat (6) @(negedge clk); start = 0; repeat (12) @(negedge clk);
  endtask

  task automatic send_header(input logic [15:0] c, input logic [15:0] n);
    logic [15:0] rx;
    sb_q.push_back('{0, c, tb_clamp(n)});
    cs_lo();
    spi_bits(16'hCB07, 16, rx); spi_bits(c, 16, rx); spi_bits(n, 16, rx);
    cs_hi();
    exp_rises++; ack_chk("R2 header ack");
  endtask

  task automatic do_msg(input logic [15:0] c, input logic [15:0] n, input logic [15:0] rl, input int seed);
    logic [15:0] rx;
    int nd, nr;
    nd = tb_clamp(n); nr = tb_clamp(rl);
    rep_len = rl;
    for (int i = 0; i < 16; i++) rep_mem[i] = 16'(seed * 16'h1357 + i * 16'h0F21);
    rep_base = pop_total;
    send_header(c, n);
    cs_lo();
    for (int i = 0; i < nd; i++) begin
      sb_q.push_back('{1, 16'(16'hA000 + seed * 16 + i), 16'h0});
      spi_bits(16'(16'hA000 + seed * 16 + i), 16, rx);
    end
    cs_hi(); exp_rises++; ack_chk("R4 data ack");
    cs_lo();
    spi_bits(16'h0, 16, rx); chk(rx == 16'(nr), "R5 length word", rx, nr);
    spi_bits(16'h0, 16, rx); chk(rx == 16'h0, "R5 dummy word", rx, 0);
    cs_hi(); exp_rises++; ack_chk("R5 length ack");
    cs_lo();
    for (int i = 0; i < nr; i++) begin
      spi_bits(16'h0, 16, rx); chk(rx == rep_mem[i], "R6 reply word", rx, rep_mem[i]);
    end
    cs_hi(); exp_rises++; ack_chk("R6 reply ack");
    chk(pop_total - rep_base == nr, "R6 pop count", pop_total - rep_base, nr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] rx;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ack == 0 && miso == 0, "R1 ack/miso", {ack, miso}, 0);
    chk(!cmd_valid && !rx_valid && !rep_pop && !uart_pop, "R1 strobes", 0, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R7 start after reset gives a ready pulse
    pulse_start(); exp_rises++; ack_chk("R7 start ack");

    // R3 bad sync word discarded, no ack
    cs_lo(); spi_bits(16'h1234, 16, rx); cs_hi();
    ack_chk("R3 no ack on bad sync");
    do_msg(16'h00A5, 16'd3, 16'd2, 1);

    // R4/R5/R6 zero counts clamp to one
    do_msg(16'h0011, 16'd0, 16'd0, 2);
    // R4/R5/R6 oversize counts clamp to MAX_WORDS
    do_msg(16'h0022, 16'hFFFF, 16'd100, 3);

    // R11 partial word then cs release is discarded
    cs_lo(); spi_bits(16'hCB07, 5, rx); cs_hi();
    ack_chk("R11 no ack on partial word");
    do_msg(16'h0033, 16'd2, 16'd3, 4);

    // R7 restart in the middle of host data
    send_header(16'h0044, 16'd3);
    sb_q.push_back('{1, 16'hBEEF, 16'h0});
    cs_lo(); spi_bits(16'hBEEF, 16, rx); cs_hi();
    ack_chk("R7 no ack mid data");
    pulse_start(); exp_rises++; ack_chk("R7 restart ack");
    do_msg(16'h0055, 16'd1, 16'd1, 5);

    // R9 held level for pending serial data
    hold_flag = 1; uart_word = 16'h5A3C; pend = 1;
    repeat (12) @(negedge clk);
    exp_rises++;
    chk(ack == 1, "R9 ack held", ack, 1);
    ack_chk("R9 single rise");
    // R10 start ignored during hold
    pulse_start();
    chk(ack == 1, "R10 ack still held", ack, 1);
    ack_chk("R10 no extra pulse");
    sb_q.push_back('{2, 16'h0, 16'h0});
    cs_lo(); spi_bits(16'h1111, 16, rx); cs_hi();
    chk(rx == 16'h5A3C, "R10 serial word after start", rx, 16'h5A3C);
    uart_word = 16'h0F0F;
    sb_q.push_back('{2, 16'h0, 16'h0});
    cs_lo(); spi_bits(16'h2222, 16, rx); cs_hi();
    chk(rx == 16'h0F0F, "R9 second serial word", rx, 16'h0F0F);
    pend = 0;
    repeat (8) @(negedge clk);
    chk(ack == 0, "R9 ack released", ack, 0);
    hold_flag = 0;
    do_msg(16'h0066, 16'd2, 16'd2, 6);

    chk(sb_q.size() == 0, "R2/R4/R9 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule